// File: doc/BRIEF.md
# Galois-Field Weighted Parity Combiner

This block is the arithmetic core of a RAID5/RAID6 parity offload. It takes a stream of source bytes and folds them, one byte offset at a time, into one or two parity bytes. Each source byte can be scaled by its own coefficient in GF(2^8) before it is XORed into the running result. Plain RAID5 parity is the case where every coefficient is 1. The RAID6 syndrome pair is produced in a single pass: P is the plain XOR and Q is the weighted sum.

A command is accepted while the unit is idle. It carries an operation code, the number of sources per offset, the number of offsets, and a vector of per-source coefficients. Source bytes then arrive on a valid/ready stream. For each offset, the bytes come in source-index order. One cycle after the last source byte of an offset is taken, the unit presents the result for one cycle. Once the last offset is done, the unit returns to idle. A parity update can be folded into a new pass by appending the old P and the old Q (twice) as extra sources, with Q weights 0, 0 and 1.

Top module: `gf_parity_unit`

## Requirements
- R1: While reset is high and right after it is released, `cmd_ready` is 1, `src_ready` is 0, `res_valid` is 0 and `err` is 0.
- R2: Field multiplication uses the reduction polynomial x^8+x^4+x^3+x^2+1. For example, 0x80 scaled by 0x02 gives 0x1D, and the product is correct for all 256x256 operand pairs.
- R3: Opcode 0x1A is weighted single-result mode. `res_q` equals the XOR over i of coef[i]·src[i], where coef[i] is byte i of `cmd_coef` (bits 8i+7..8i), `res_dual` is 0, and `res_valid` is high exactly in the cycle after the handshake of the last source of an offset and low after every other handshake.
- R4: In opcode 0x1A with every coefficient equal to 1, `res_q` is the plain XOR of the sources.
- R5: Opcode 0x1B is dual-result mode. `res_p` is the XOR of all sources, `res_q` is the weighted sum, and `res_dual` is 1 while `res_valid` is high. Idle cycles on the source stream do not change the result.
- R6: A single real source can produce Q alone. Issue opcode 0x1A with two sources, send the same byte twice, and use coefficients {c, 0}. The result is c·s.
- R7: In dual mode, appending old P, old Q, old Q with Q coefficients 0, 0, 1 yields P = oldP XOR (XOR of new sources) and Q = oldQ XOR (weighted new sources).
- R8: Opcode 0x08 is move. Every accepted byte is returned on `res_q` one cycle later with `res_dual` 0. The source-count field and the coefficients are ignored.
- R9: A command runs for `cmd_len_m1`+1 offsets of `cmd_cnt_m1`+1 sources. `src_ready` is 1 only while a command runs, and `cmd_ready` returns to 1 right after the last handshake.
- R10: An opcode other than 0x08/0x1A/0x1B, or opcode 0x1B with `cmd_cnt_m1` = 0, sets `err`. The unit stays idle (`cmd_ready` 1, `src_ready` 0, no result), `err` holds until reset, and later legal commands still run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_op | input | 8 | Operation code (0x08 move, 0x1A single, 0x1B dual) |
| cmd_cnt_m1 | input | SRC_W (4) | Sources per offset minus one |
| cmd_len_m1 | input | LEN_W (12) | Byte offsets in the command minus one |
| cmd_coef | input | 8*MAX_SRC (128) | Coefficient of source i in bits 8i+7..8i |
| src_valid | input | 1 | Source byte offered |
| src_ready | output | 1 | Source byte can be taken |
| src_data | input | 8 | Source byte |
| res_valid | output | 1 | Result of one offset present (one cycle) |
| res_dual | output | 1 | Result carries both P and Q |
| res_p | output | 8 | Plain XOR parity |
| res_q | output | 8 | Weighted parity / single result / moved byte |
| err | output | 1 | Sticky illegal-command flag |

## Verification
The multiplier is swept over every coefficient and byte pair. A wrong reduction constant or a dropped partial product would therefore corrupt a whole family of products, not just one rare value. Source counts are swept from 1 to 16. This catches an accumulator that is not cleared at index 0, which would leak the previous offset into the next, and a coefficient lookup off by one index, which would put the wrong weights on the wrong bytes. Continuation with its 0,0,1 tail shows whether the old Q is cancelled or doubled. Move is run with a non-zero count field, and a design that honoured that field would wait for six bytes. The error cases check that a rejected command neither opens the stream nor emits a result, and that the flag survives a later legal command.

// File: rtl/gfp_pkg.sv
package gfp_pkg;

    localparam int GF_W = 8;
    localparam logic [GF_W-1:0] GF_POLY_LOW = 8'h1D;

    localparam logic [7:0] OPC_MOVE = 8'h08;
    localparam logic [7:0] OPC_WSUM = 8'h1A;
    localparam logic [7:0] OPC_DUAL = 8'h1B;

    typedef enum logic [1:0] {
        MD_MOVE   = 2'd0,
        MD_SINGLE = 2'd1,
        MD_DUAL   = 2'd2
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    typedef struct packed {
        logic  legal;
        mode_e mode;
    } decode_t;

    // multiply by x modulo the field polynomial
    function automatic logic [GF_W-1:0] gf_xtime(input logic [GF_W-1:0] v);
        return {v[GF_W-2:0], 1'b0} ^ (v[GF_W-1] ? GF_POLY_LOW : '0);
    endfunction

    function automatic decode_t decode_op(input logic [7:0] op, input logic one_src);
        decode_t d;
        d.legal = 1'b1;
        d.mode  = MD_SINGLE;
        case (op)
            OPC_MOVE: d.mode = MD_MOVE;
            OPC_WSUM: d.mode = MD_SINGLE;
            OPC_DUAL: begin
                d.mode = MD_DUAL;
                if (one_src) d.legal = 1'b0;
            end
            default: d.legal = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gfp_mul.sv
module gfp_mul
    import gfp_pkg::*;
(
    input  logic [GF_W-1:0] a,
    input  logic [GF_W-1:0] b,
    output logic [GF_W-1:0] y
);
    // shift-and-reduce: partial products a*x^k gated by b[k]
    always_comb begin
        logic [GF_W-1:0] pw;
        pw = a;
        y  = '0;
        for (int k = 0; k < GF_W; k++) begin
            if (b[k]) y = y ^ pw;
            pw = gf_xtime(pw);
        end
    end
endmodule

// File: rtl/gfp_acc.sv
module gfp_acc
    import gfp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            first,
    input  logic [GF_W-1:0] term,
    output logic [GF_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (en) begin
            acc <= (first ? '0 : acc) ^ term;
        end
    end
endmodule

// File: rtl/gfp_seq.sv
module gfp_seq
    import gfp_pkg::*;
#(
    parameter int MAX_SRC = 16,
    parameter int LEN_W   = 12,
    localparam int SRC_W  = (MAX_SRC > 1) ? $clog2(MAX_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_op,
    input  logic [SRC_W-1:0] cmd_cnt_m1,
    input  logic [LEN_W-1:0] cmd_len_m1,
    output logic             cmd_ready,
    output logic             take_cmd,
    input  logic             src_valid,
    output logic             src_ready,
    output logic             beat,
    output logic             first,
    output logic [SRC_W-1:0] idx,
    output logic             res_valid,
    output mode_e            mode,
    output logic             err
);
    state_e           state;
    logic [SRC_W-1:0] cnt_lim;
    logic [LEN_W-1:0] len_lim;
    logic [LEN_W-1:0] off;
    logic             last;
    decode_t          dec;

    assign dec       = decode_op(cmd_op, cmd_cnt_m1 == '0);
    assign cmd_ready = (state == ST_IDLE);
    assign take_cmd  = cmd_valid && cmd_ready && dec.legal;
    assign src_ready = (state == ST_RUN);
    assign beat      = src_valid && src_ready;
    assign first     = (idx == '0);
    assign last      = (idx == cnt_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt_lim   <= '0;
            len_lim   <= '0;
            off       <= '0;
            idx       <= '0;
            mode      <= MD_SINGLE;
            err       <= 1'b0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= beat && last;
            if (cmd_valid && cmd_ready) begin
                if (dec.legal) begin
                    state   <= ST_RUN;
                    mode    <= dec.mode;
                    cnt_lim <= (dec.mode == MD_MOVE) ? '0 : cmd_cnt_m1;
                    len_lim <= cmd_len_m1;
                    off     <= '0;
                    idx     <= '0;
                end else begin
                    err <= 1'b1;
                end
            end
            if (beat) begin
                if (last) begin
                    idx <= '0;
                    if (off == len_lim) begin
                        state <= ST_IDLE;
                    end else begin
                        off <= off + 1'b1;
                    end
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/gf_parity_unit.sv
module gf_parity_unit
    import gfp_pkg::*;
#(
    parameter int MAX_SRC = 16,
    parameter int LEN_W   = 12,
    localparam int SRC_W  = (MAX_SRC > 1) ? $clog2(MAX_SRC) : 1,
    localparam int COEF_W = MAX_SRC * GF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [7:0]        cmd_op,
    input  logic [SRC_W-1:0]  cmd_cnt_m1,
    input  logic [LEN_W-1:0]  cmd_len_m1,
    input  logic [COEF_W-1:0] cmd_coef,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [GF_W-1:0]   src_data,
    output logic              res_valid,
    output logic              res_dual,
    output logic [GF_W-1:0]   res_p,
    output logic [GF_W-1:0]   res_q,
    output logic              err
);
    logic             take_cmd;
    logic             beat;
    logic             first;
    logic [SRC_W-1:0] idx;
    mode_e            mode_r;
    logic [GF_W-1:0]  coef_q [MAX_SRC];
    logic [GF_W-1:0]  coef_eff;
    logic [GF_W-1:0]  q_term;

    gfp_seq #(.MAX_SRC(MAX_SRC), .LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_cnt_m1 (cmd_cnt_m1),
        .cmd_len_m1 (cmd_len_m1),
        .cmd_ready  (cmd_ready),
        .take_cmd   (take_cmd),
        .src_valid  (src_valid),
        .src_ready  (src_ready),
        .beat       (beat),
        .first      (first),
        .idx        (idx),
        .res_valid  (res_valid),
        .mode       (mode_r),
        .err        (err)
    );

    // one coefficient register per source lane
    for (genvar g = 0; g < MAX_SRC; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                coef_q[g] <= '0;
            end else if (take_cmd) begin
                coef_q[g] <= cmd_coef[g*GF_W +: GF_W];
            end
        end
    end

    assign coef_eff = (mode_r == MD_MOVE) ? GF_W'(1) : coef_q[idx];

    gfp_mul u_mul (
        .a (src_data),
        .b (coef_eff),
        .y (q_term)
    );

    gfp_acc u_acc_p (
        .clk   (clk),
        .rst   (rst),
        .en    (beat),
        .first (first),
        .term  (src_data),
        .acc   (res_p)
    );

    gfp_acc u_acc_q (
        .clk   (clk),
        .rst   (rst),
        .en    (beat),
        .first (first),
        .term  (q_term),
        .acc   (res_q)
    );

    assign res_dual = res_valid && (mode_r == MD_DUAL);
endmodule

// File: rtl/gfp_checker.sv
module gfp_checker
    import gfp_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cmd_ready,
    input logic            src_valid,
    input logic            src_ready,
    input logic [GF_W-1:0] src_data,
    input logic            res_valid,
    input logic [GF_W-1:0] res_q,
    input logic            err,
    input mode_e           mode
);
    AST_RESULT_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(src_valid && src_ready)); // R3

    AST_RESULT_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !$past(cmd_ready)); // R9

    AST_IDLE_CLOSED: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !src_ready); // R9

    AST_MOVE_PASS: assert property (@(posedge clk) disable iff (rst)
        (res_valid && mode == MD_MOVE) |-> (res_q == $past(src_data))); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R10

    AST_ERR_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (cmd_ready && !src_ready)); // R10
endmodule

bind gf_parity_unit gfp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_ready (cmd_ready),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .src_data  (src_data),
    .res_valid (res_valid),
    .res_q     (res_q),
    .err       (err),
    .mode      (mode_r)
);

// File: tb/gf_parity_unit_test.sv
module gf_parity_unit_test;
    localparam int NS = 16;
    localparam int LW = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [7:0]       cmd_op = '0;
    logic [3:0]       cmd_cnt_m1 = '0;
    logic [LW-1:0]    cmd_len_m1 = '0;
    logic [NS*8-1:0]  cmd_coef = '0;
    logic             src_valid = 1'b0;
    logic             src_ready;
    logic [7:0]       src_data = '0;
    logic             res_valid;
    logic             res_dual;
    logic [7:0]       res_p;
    logic [7:0]       res_q;
    logic             err;

    always #10 clk = ~clk;

    gf_parity_unit #(.MAX_SRC(NS), .LEN_W(LW)) uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_cnt_m1(cmd_cnt_m1), .cmd_len_m1(cmd_len_m1), .cmd_coef(cmd_coef),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .res_valid(res_valid), .res_dual(res_dual), .res_p(res_p), .res_q(res_q),
        .err(err)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    logic [7:0]  gexp [0:255];
    int          glog [0:255];
    logic [31:0] rng = 32'h1234_5678;
    logic [7:0]  bcoef [0:NS-1];
    logic [7:0]  bsrc  [0:NS-1];

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        if (a == 0 || b == 0) return 8'h00;
        return gexp[(glog[a] + glog[b]) % 255];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic rnd(output logic [7:0] v);
        rng = rng * 32'd1664525 + 32'd1013904223;
        v = rng[23:16];
    endtask

    task automatic send_cmd(input logic [7:0] op, input int cnt_m1, input int len_m1);
        for (int i = 0; i < NS; i++) cmd_coef[i*8 +: 8] = bcoef[i];
        cmd_op     = op;
        cmd_cnt_m1 = 4'(cnt_m1);
        cmd_len_m1 = LW'(len_m1);
        cmd_valid  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    // one source byte; entered and left at a falling edge
    task automatic beat(input logic [7:0] d, input bit last, input logic [7:0] ep,
                        input logic [7:0] eq, input bit edual, input string tag);
        src_valid = 1'b1;
        src_data  = d;
        @(posedge clk);
        @(negedge clk);
        src_valid = 1'b0;
        if (last) begin
            chk({tag, " res_valid after last"}, res_valid, 1);
            chk({tag, " res_q"}, res_q, eq);
            chk({tag, " res_dual"}, res_dual, edual);
            if (edual) chk({tag, " res_p"}, res_p, ep);
        end else begin
            chk({tag, " R3 no result mid-offset"}, res_valid, 0);
        end
    endtask

    // kind: 0 single, 1 dual, 2 move; cont appends oldP, oldQ, oldQ
    task automatic run_cmd(input int kind, input logic [7:0] op, input int n,
                           input int cnt_field, input int len, input bit cont,
                           input bit gap, input string tag);
        logic [7:0] ep, eq, v, oldp, oldq;
        int nreal;
        send_cmd(op, cnt_field, len - 1);
        nreal = cont ? n - 3 : n;
        for (int o = 0; o < len; o++) begin
            ep = 0;
            eq = 0;
            for (int i = 0; i < nreal; i++) begin
                rnd(v);
                bsrc[i] = v;
                ep ^= v;
                eq ^= ref_mul(bcoef[i], v);
            end
            if (cont) begin
                rnd(oldp);
                rnd(oldq);
                bsrc[n-3] = oldp;
                bsrc[n-2] = oldq;
                bsrc[n-1] = oldq;
                ep ^= oldp;
                eq ^= oldq;
            end
            if (kind == 2) eq = bsrc[0];
            for (int i = 0; i < n; i++) begin
                if (gap && i == 1) @(negedge clk);
                beat(bsrc[i], i == n - 1, ep, eq, kind == 1, tag);
            end
        end
        chk({tag, " R9 idle after last offset"}, {30'd0, cmd_ready, src_ready}, 2'b10);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] x, c, s;
        x = 8'h01;
        for (int i = 0; i < 255; i++) begin
            gexp[i] = x;
            glog[x] = i;
            x = (x << 1) ^ ((x & 8'h80) != 0 ? 8'h1D : 8'h00);
        end
        gexp[255] = gexp[0];
        glog[0] = 0;
        for (int i = 0; i < NS; i++) bcoef[i] = 0;

        // R1 reset state
        @(negedge clk);
        chk("R1 cmd_ready in reset", cmd_ready, 1);
        do_reset();
        chk("R1 cmd_ready", cmd_ready, 1);
        chk("R1 src_ready", src_ready, 0);
        chk("R1 res_valid", res_valid, 0);
        chk("R1 err", err, 0);

        // R2 exhaustive field product, plus the named corner 0x80*0x02
        bcoef[0] = 8'h02;
        send_cmd(8'h1A, 0, 0);
        beat(8'h80, 1, 0, 8'h1D, 0, "R2 x^7*x");
        for (int ci = 0; ci < 256; ci++) begin
            bcoef[0] = 8'(ci);
            send_cmd(8'h1A, 0, 255);
            for (int si = 0; si < 256; si++)
                beat(8'(si), 1, 0, ref_mul(8'(ci), 8'(si)), 0, "R2");
        end

        // R3 weighted single result, every source count
        for (int n = 1; n <= NS; n++) begin
            for (int i = 0; i < NS; i++) begin rnd(c); bcoef[i] = c; end
            run_cmd(0, 8'h1A, n, n - 1, 3, 0, 0, "R3");
        end

        // R4 plain XOR through unit coefficients
        for (int i = 0; i < NS; i++) bcoef[i] = 8'h01;
        for (int n = 1; n <= NS; n++) run_cmd(0, 8'h1A, n, n - 1, 2, 0, 0, "R4");

        // R5 dual result, with an idle cycle inside each offset
        for (int n = 2; n <= NS; n++) begin
            for (int i = 0; i < NS; i++) begin rnd(c); bcoef[i] = c; end
            run_cmd(1, 8'h1B, n, n - 1, 3, 0, 1, "R5");
        end

        // R6 Q only from one source
        for (int k = 0; k < 6; k++) begin
            rnd(c);
            bcoef[0] = c;
            bcoef[1] = 8'h00;
            send_cmd(8'h1A, 1, 3);
            for (int o = 0; o < 4; o++) begin
                rnd(s);
                beat(s, 0, 0, 0, 0, "R6");
                beat(s, 1, 0, ref_mul(c, s), 0, "R6");
            end
        end

        // R7 continuation with appended old parity
        for (int nr = 1; nr <= NS - 3; nr++) begin
            for (int i = 0; i < NS; i++) begin rnd(c); bcoef[i] = c; end
            bcoef[nr]     = 8'h00;
            bcoef[nr + 1] = 8'h00;
            bcoef[nr + 2] = 8'h01;
            run_cmd(1, 8'h1B, nr + 3, nr + 2, 2, 1, 0, "R7");
        end

        // R8 move ignores count field and coefficients
        bcoef[0] = 8'h37;
        run_cmd(2, 8'h08, 1, 5, 8, 0, 0, "R8");

        // R10 unsupported opcode
        send_cmd(8'h55, 3, 0);
        chk("R10 err on bad opcode", err, 1);
        chk("R10 stays idle", {30'd0, cmd_ready, src_ready}, 2'b10);
        src_valid = 1'b1;
        src_data  = 8'hA5;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R10 no result after reject", res_valid, 0);
        end
        src_valid = 1'b0;
        for (int i = 0; i < NS; i++) begin rnd(c); bcoef[i] = c; end
        run_cmd(0, 8'h1A, 3, 2, 2, 0, 0, "R10 legal after error");
        chk("R10 err sticky", err, 1);
        do_reset();
        chk("R10 err cleared by reset", err, 0);

        // R10 dual mode with one source
        send_cmd(8'h1B, 0, 0);
        chk("R10 err on one-source dual", err, 1);
        chk("R10 stays idle dual", {30'd0, cmd_ready, src_ready}, 2'b10);
        @(negedge clk);
        chk("R10 no result dual", res_valid, 0);

        finish_run();
    end
endmodule